// File: doc/BRIEF.md
# Dual-Bank Affine Colour Matrix

This block transforms a stream of RGB pixels with a 3x4 affine matrix. Each output channel is the dot product of one matrix row with the input pixel, plus that row's offset term, rounded and clamped to the pixel range. Two complete coefficient banks (A and B) live in host-writable registers, each coefficient a signed fixed-point value packed two to a 32-bit word. A host writes the idle bank at leisure, requests it through the control word, and the block switches over on the next frame-start pulse. A read-only field in the control word shows which bank the datapath is actually using.

The active selection is held by a small state machine with three states: `ST_BYPASS`, `ST_SET_A` and `ST_SET_B`. On a cycle with `frame_start` high, the machine takes the transition named by the requested mode: a request of 1 moves to `ST_SET_A`, a request of 2 moves to `ST_SET_B`, and a request of 0 or 3 moves to `ST_BYPASS`. Without `frame_start` every state holds. The pixel that arrives together with the frame-start pulse is already processed in the newly chosen mode.

The pixel path is a three-stage pipeline. Stage one captures the pixel and the effective mode. Stage two forms the four-term sum. Stage three rounds, clamps or passes the pixel through. `out_valid` is `in_valid` delayed by the same three stages.

Top module: `cmx_remap`

## Requirements
- R1: Address 0 is the control word: bits [1:0] hold the requested mode (read/write) and bits [5:4] show the current mode (read-only); writes to any other bit of it are ignored and read as 0. Addresses 1..6 hold bank A words 0..5 and addresses 7..12 hold bank B words 0..5. Word n carries coefficient 2n in bits [15:0] and coefficient 2n+1 in bits [31:16], with coefficients ordered row-major as C11, C12, C13, C14, C21, ..., C34. Any other address reads 0.
- R2: Mode encoding: 0 = bypass, 1 = bank A, 2 = bank B, 3 = bypass. On a `frame_start` pulse the requested mode becomes the current mode. The current-mode field reads 0, 1 or 2, and a request of 3 is reported as 0.
- R3: Without a `frame_start` pulse the current mode and the output behaviour do not change, whatever is written to the requested mode.
- R4: A pixel presented in the same cycle as `frame_start` is processed with the newly selected mode.
- R5: In bank mode, output channel i equals floor((Ci1*R + Ci2*G + Ci3*B + Ci4*4096 + 4096) / 8192), clamped to 0..4095. Each coefficient is 16-bit two's complement with 13 fraction bits, and pixels are 12-bit unsigned.
- R6: In bypass mode each output channel equals the corresponding input channel.
- R7: Latency is exactly three clock cycles: `out_valid` is `in_valid` delayed by three cycles, and the output data belongs to that input.
- R8: Writing the bank not in use has no effect on the output of the bank in use.
- R9: After reset the current mode is bypass, the requested mode is 0, every coefficient word is 0 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| frame_start | input | 1 | One-cycle pulse marking the first pixel of a frame |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | 12 | Input red |
| in_g | input | 12 | Input green |
| in_b | input | 12 | Input blue |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 12 | Output red |
| out_g | output | 12 | Output green |
| out_b | output | 12 | Output blue |

## Verification
A wrong current state shows up two ways. The current-mode field at address 0 reads back wrongly as soon as the transition is missed. The very next pixel then leaves the pipeline three cycles later with bypass values where matrix values were expected, or with results from the wrong bank. A mistake in word packing or in the order of coefficients within a row puts a coefficient on the wrong colour, so the pixels are chosen so that every coefficient position produces a distinct result. Rounding and clamping are shown by pixels that land exactly on a half step, above full scale and below zero. A fault in the valid delay shows at the port as a strobe one cycle early or late.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
    localparam int MTX_ROWS  = 3;
    localparam int MTX_COLS  = 4;
    localparam int NUM_COEF  = MTX_ROWS * MTX_COLS;
    localparam int NUM_WORDS = NUM_COEF / 2;
    localparam int NUM_BANKS = 2;

    localparam logic [1:0] REQ_BYPASS  = 2'd0;
    localparam logic [1:0] REQ_SET_A   = 2'd1;
    localparam logic [1:0] REQ_SET_B   = 2'd2;
    localparam logic [1:0] REQ_BYPASS2 = 2'd3;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_SET_A  = 2'd1,
        ST_SET_B  = 2'd2
    } cur_state_e;
endpackage

// File: rtl/cmx_regfile.sv
module cmx_regfile
    import cmx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [1:0]                  cur_code,
    output logic [DATA_W-1:0]           rdata,
    output logic [1:0]                  req_mode,
    output logic [NUM_WORDS*DATA_W-1:0] bank_a,
    output logic [NUM_WORDS*DATA_W-1:0] bank_b
);
    localparam int LAST_ADDR = NUM_BANKS * NUM_WORDS;

    logic [DATA_W-1:0] words [NUM_BANKS][NUM_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_mode <= REQ_BYPASS;
            for (int b = 0; b < NUM_BANKS; b++)
                for (int w = 0; w < NUM_WORDS; w++)
                    words[b][w] <= '0;
        end else if (we) begin
            if (addr == '0)
                req_mode <= wdata[1:0];
            for (int b = 0; b < NUM_BANKS; b++)
                for (int w = 0; w < NUM_WORDS; w++)
                    if (int'(addr) == 1 + b * NUM_WORDS + w)
                        words[b][w] <= wdata;
        end
    end

    genvar gw;
    generate
        for (gw = 0; gw < NUM_WORDS; gw++) begin : g_flat
            assign bank_a[gw*DATA_W +: DATA_W] = words[0][gw];
            assign bank_b[gw*DATA_W +: DATA_W] = words[1][gw];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata[1:0] = req_mode;
            rdata[5:4] = cur_code;
        end else if (int'(addr) <= LAST_ADDR) begin
            for (int b = 0; b < NUM_BANKS; b++)
                for (int w = 0; w < NUM_WORDS; w++)
                    if (int'(addr) == 1 + b * NUM_WORDS + w)
                        rdata = words[b][w];
        end
    end

    assert_ctrl_write_keeps_coefs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == '0) |=> ($stable(bank_a) && $stable(bank_b)));

    assert_bank_b_write_spares_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) > NUM_WORDS) |=> $stable(bank_a));
endmodule

// File: rtl/cmx_mode_fsm.sv
module cmx_mode_fsm
    import cmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] req_mode,
    output logic [1:0] cur_code,
    output logic       pix_bypass,
    output logic       pix_use_b
);
    cur_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            unique case (req_mode)
                REQ_SET_A:   state_d = ST_SET_A;
                REQ_SET_B:   state_d = ST_SET_B;
                REQ_BYPASS,
                REQ_BYPASS2: state_d = ST_BYPASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_BYPASS;
        else
            state_q <= state_d;
    end

    always_comb begin
        cur_code   = 2'd0;
        pix_bypass = 1'b1;
        pix_use_b  = 1'b0;
        unique case (state_q)
            ST_SET_A: cur_code = 2'd1;
            ST_SET_B: cur_code = 2'd2;
            default:  cur_code = 2'd0;
        endcase
        unique case (state_d)
            ST_SET_A: pix_bypass = 1'b0;
            ST_SET_B: begin
                pix_bypass = 1'b0;
                pix_use_b  = 1'b1;
            end
            default:  pix_bypass = 1'b1;
        endcase
    end

    assert_hold_without_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cur_code));

    assert_code3_reports_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && req_mode == 2'd3) |=> cur_code == 2'd0);

    assert_set_b_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && req_mode == 2'd2) |=> cur_code == 2'd2);

    assert_same_cycle_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && req_mode == 2'd1) |-> (!pix_bypass && !pix_use_b));
endmodule

// File: rtl/cmx_channel.sv
module cmx_channel #(
    parameter int PIX_W  = 12,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIX_W-1:0]      pix_r,
    input  logic [PIX_W-1:0]      pix_g,
    input  logic [PIX_W-1:0]      pix_b,
    input  logic [PIX_W-1:0]      pix_own,
    input  logic                  bypass,
    input  logic [4*COEF_W-1:0]   row_coef,
    output logic [PIX_W-1:0]      out_pix
);
    localparam int ACC_W = COEF_W + PIX_W + 4;
    localparam logic signed [ACC_W-1:0] ROUND_ADD = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] PIX_MAX   = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] tap_c [4];
    logic signed [ACC_W-1:0] tap_p [4];
    logic signed [ACC_W-1:0] sum_d, acc_q, scaled;
    logic                    byp_q;
    logic [PIX_W-1:0]        own_q;

    genvar gt;
    generate
        for (gt = 0; gt < 4; gt++) begin : g_tap
            assign tap_c[gt] = {{(ACC_W-COEF_W){row_coef[gt*COEF_W+COEF_W-1]}},
                                row_coef[gt*COEF_W +: COEF_W]};
        end
    endgenerate

    assign tap_p[0] = {{(ACC_W-PIX_W){1'b0}}, pix_r};
    assign tap_p[1] = {{(ACC_W-PIX_W){1'b0}}, pix_g};
    assign tap_p[2] = {{(ACC_W-PIX_W){1'b0}}, pix_b};
    assign tap_p[3] = ACC_W'(1) <<< PIX_W;

    always_comb begin
        sum_d = '0;
        for (int k = 0; k < 4; k++)
            sum_d = sum_d + tap_c[k] * tap_p[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            byp_q <= 1'b1;
            own_q <= '0;
        end else begin
            acc_q <= sum_d;
            byp_q <= bypass;
            own_q <= pix_own;
        end
    end

    assign scaled = (acc_q + ROUND_ADD) >>> FRAC_W;

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_pix <= '0;
        else if (byp_q)
            out_pix <= own_q;
        else if (scaled < 0)
            out_pix <= '0;
        else if (scaled > PIX_MAX)
            out_pix <= PIX_MAX[PIX_W-1:0];
        else
            out_pix <= scaled[PIX_W-1:0];
    end

    assert_neg_sum_clamps_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp_q && acc_q[ACC_W-1]) |=> out_pix == '0);
endmodule

// File: rtl/cmx_remap.sv
module cmx_remap
    import cmx_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 13,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);
    localparam int DATA_W = 2 * COEF_W;
    localparam int BANK_W = NUM_WORDS * DATA_W;
    localparam int ROW_W  = MTX_COLS * COEF_W;

    logic [1:0]        req_mode, cur_code;
    logic              pix_bypass, pix_use_b;
    logic [BANK_W-1:0] bank_a, bank_b, bank_sel;
    logic [31:0]       rdata_w;

    cmx_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (DATA_W'(cfg_wdata)),
        .cur_code (cur_code),
        .rdata    (rdata_w),
        .req_mode (req_mode),
        .bank_a   (bank_a),
        .bank_b   (bank_b)
    );
    assign cfg_rdata = rdata_w;

    cmx_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .req_mode    (req_mode),
        .cur_code    (cur_code),
        .pix_bypass  (pix_bypass),
        .pix_use_b   (pix_use_b)
    );

    logic             v1, v2, v3;
    logic             byp1, useb1;
    logic [PIX_W-1:0] pix1 [MTX_ROWS];
    logic [PIX_W-1:0] outp [MTX_ROWS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            v2    <= 1'b0;
            v3    <= 1'b0;
            byp1  <= 1'b1;
            useb1 <= 1'b0;
            for (int i = 0; i < MTX_ROWS; i++)
                pix1[i] <= '0;
        end else begin
            v1      <= in_valid;
            v2      <= v1;
            v3      <= v2;
            byp1    <= pix_bypass;
            useb1   <= pix_use_b;
            pix1[0] <= in_r;
            pix1[1] <= in_g;
            pix1[2] <= in_b;
        end
    end

    assign bank_sel = useb1 ? bank_b : bank_a;

    genvar gc;
    generate
        for (gc = 0; gc < MTX_ROWS; gc++) begin : g_chan
            cmx_channel #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .pix_r    (pix1[0]),
                .pix_g    (pix1[1]),
                .pix_b    (pix1[2]),
                .pix_own  (pix1[gc]),
                .bypass   (byp1),
                .row_coef (bank_sel[gc*ROW_W +: ROW_W]),
                .out_pix  (outp[gc])
            );
        end
    endgenerate

    assign out_valid = v3;
    assign out_r     = outp[0];
    assign out_g     = outp[1];
    assign out_b     = outp[2];

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid);

    assert_idle_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##2 !out_valid);
endmodule

// File: tb/cmx_remap_test.sv
module cmx_remap_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_r = '0, in_g = '0, in_b = '0;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int ca [12];
    int cb [12];

    always #10 clk = ~clk;

    cmx_remap uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
        .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model(input int c0, input int c1, input int c2, input int c3,
                                 input int r, input int g, input int b);
        int acc, s;
        acc = c0 * r + c1 * g + c2 * b + c3 * 4096 + 4096;
        s = acc >>> 13;
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        return s;
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int addr, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = 4'(addr);
        #1;
        check(tag, int'(cfg_rdata), int'(exp));
    endtask

    task automatic load_bank(input bit use_b);
        for (int w = 0; w < 6; w++) begin
            if (use_b) wr(7 + w, {16'(cb[2*w+1]), 16'(cb[2*w])});
            else       wr(1 + w, {16'(ca[2*w+1]), 16'(ca[2*w])});
        end
    endtask

    // mode: 0 bypass, 1 bank A, 2 bank B (expected behaviour for this pixel)
    task automatic pix(input string tag, input bit fs, input int mode,
                       input int r, input int g, input int b);
        int er, eg, eb;
        if (mode == 1) begin
            er = model(ca[0], ca[1], ca[2], ca[3], r, g, b);
            eg = model(ca[4], ca[5], ca[6], ca[7], r, g, b);
            eb = model(ca[8], ca[9], ca[10], ca[11], r, g, b);
        end else if (mode == 2) begin
            er = model(cb[0], cb[1], cb[2], cb[3], r, g, b);
            eg = model(cb[4], cb[5], cb[6], cb[7], r, g, b);
            eb = model(cb[8], cb[9], cb[10], cb[11], r, g, b);
        end else begin
            er = r; eg = g; eb = b;
        end
        @(negedge clk);
        in_valid = 1'b1; frame_start = fs;
        in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
        @(negedge clk);
        in_valid = 1'b0; frame_start = 1'b0;
        @(negedge clk);
        check({tag, " R7 no early valid"}, int'(out_valid), 0);
        @(negedge clk);
        check({tag, " R7 valid at 3"}, int'(out_valid), 1);
        check({tag, " red"}, int'(out_r), er);
        check({tag, " green"}, int'(out_g), eg);
        check({tag, " blue"}, int'(out_b), eb);
    endtask

    task automatic t_reset;
        rd_chk("R9 control after reset", 0, 32'h0);
        rd_chk("R9 coef word after reset", 1, 32'h0);
        rd_chk("R9 bank B word after reset", 12, 32'h0);
        check("R9 out_valid after reset", int'(out_valid), 0);
        rd_chk("R1 unmapped address 13", 13, 32'h0);
        rd_chk("R1 unmapped address 15", 15, 32'h0);
    endtask

    task automatic t_bypass;
        pix("R6 bypass pixel", 1'b0, 0, 100, 2000, 4095);
        pix("R6 bypass zero", 1'b0, 0, 0, 0, 0);
    endtask

    task automatic t_bank_a;
        ca = '{8192, 0, 0, 0,   0, 12288, 0, 0,   0, 0, 8192, -2048};
        load_bank(1'b0);
        rd_chk("R1 bank A word 1 packing", 2, {16'(ca[3]), 16'(ca[2])});
        rd_chk("R1 bank A word 5 packing", 6, {16'(ca[11]), 16'(ca[10])});
        wr(0, 32'h1);
        rd_chk("R2 request A pending", 0, 32'h01);
        pix("R3 no frame start stays bypass", 1'b0, 0, 4000, 4000, 500);
        pix("R4 switch on frame start pixel", 1'b1, 1, 4000, 4000, 500);
        rd_chk("R2 current reads A", 0, 32'h11);
        pix("R5 bank A mid range", 1'b0, 1, 3, 1000, 3000);
    endtask

    task automatic t_bank_b;
        cb = '{4096, 4096, 0, 0,   0, 0, 0, 8192,   -8192, 0, 8192, 2048};
        load_bank(1'b1);
        pix("R8 bank B write leaves A output", 1'b0, 1, 3, 1000, 3000);
        rd_chk("R1 bank B word 3 packing", 10, {16'(cb[7]), 16'(cb[6])});
        wr(0, 32'h0000_00F6);
        rd_chk("R1 control ignores upper bits", 0, 32'h12);
        pix("R3 request B pending", 1'b0, 1, 200, 300, 400);
        pix("R2 switch to bank B", 1'b1, 2, 1, 2, 0);
        rd_chk("R2 current reads B", 0, 32'h22);
        pix("R5 bank B clamp low", 1'b0, 2, 4095, 4095, 0);
    endtask

    task automatic t_code3;
        wr(0, 32'h3);
        pix("R2 code 3 bypass on frame", 1'b1, 0, 17, 2222, 3333);
        rd_chk("R2 code 3 reported as bypass", 0, 32'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_bypass;
        t_bank_a;
        t_bank_b;
        t_code3;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule